// File: doc/BRIEF.md
# Posted Write Buffer with Device-Region Ordering

The block accepts writes from a processor-side port and holds them in a small queue until an external bus master takes them. Each write carries an address, lane-aligned data, an access size (byte, halfword or word) and a region flag that marks it as normal or device memory. Writes leave the queue oldest first, one at a time, through a valid/ready handshake. The queue is the only place where write order could change, so the block also sets the rules for merging.

Normal-region writes are posted loosely. When a new normal write targets the same bus word as a pending normal entry, it is folded into that entry. This saves a bus cycle, and the later bytes win. Device-region writes are never folded, never folded into, and never widened. Each accepted device write produces exactly one bus transfer, at its own size and in acceptance order. A normal write cannot merge into an entry that sits ahead of a pending device write, so the two kinds are never reordered against each other. Software uses the drained flag as a barrier: it waits until every posted write has left.

Top module: `posted_wbuf`

## Requirements
- R1: After reset the buffer is empty. `bus_valid_o` is low, `wr_ready_o` is high and `drained_o` is high.
- R2: Entries leave on the bus in acceptance order. Each carries its address, data, size code and device flag. The byte-lane strobe follows from the size code. Code 0 is a byte in lane addr[1:0]. Code 1 is a halfword in lanes {addr[1],0} and {addr[1],1}. Code 2 is a word with all four lanes.
- R3: A normal write whose address bits above bit 1 equal those of a pending normal entry merges into that entry when three conditions hold. The entry is not the head. It is the youngest such entry. No device entry is younger than it. The merge adds no entry, overwrites only the new write's lanes, leaves the other lanes unchanged and keeps the entry's queue position.
- R4: If a merge leaves the entry's lane set unchanged, the entry keeps its size and address. Otherwise it becomes a word access (code 2) at the word-aligned address, with the union of both lane sets.
- R5: A device write is never merged and no write merges into it. Every accepted device write gives exactly one bus transfer at its issued size, even when it repeats an address.
- R6: A normal write never merges into an entry that is older than a pending device entry. It is appended instead.
- R7: The head entry is never modified by a merge. While `bus_valid_o` is high and `bus_ready_i` is low, all bus outputs hold steady.
- R8: With 4 entries held, `wr_ready_o` is low for any write that cannot merge, including every device write. It stays high for a mergeable normal write.
- R9: `drained_o` is high exactly when no entries are held. It rises only after the last entry is taken by the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write accepted this cycle when high with valid |
| wr_addr_i | input | ADDR_W | Byte address, naturally aligned to the size |
| wr_data_i | input | DATA_W | Lane-aligned write data |
| wr_size_i | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| wr_dev_i | input | 1 | High for a device-region write |
| bus_valid_o | output | 1 | Head entry presented to the bus master |
| bus_ready_i | input | 1 | Bus master takes the head entry |
| bus_addr_o | output | ADDR_W | Head entry address |
| bus_data_o | output | DATA_W | Head entry data |
| bus_size_o | output | 2 | Head entry size code |
| bus_strb_o | output | DATA_W/8 | Head entry byte-lane strobe |
| bus_dev_o | output | 1 | Head entry device flag |
| drained_o | output | 1 | No write is pending |

## Verification
The assertions take three things for granted about the inputs. Every write address is naturally aligned to its size. The size code never exceeds 2. Write data already sits in the lanes the address selects. The bench only issues aligned byte, halfword and word writes with data placed in those lanes. It holds `bus_ready_i` low while it builds merge, head-exclusion and device-fence patterns, so the queue contents are known exactly. A separate phase streams device writes while `bus_ready_i` toggles pseudo-randomly, to exercise back-pressure.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int SIZE_W = 2;
  typedef logic [SIZE_W-1:0] size_t;
  localparam size_t SZ_BYTE = 2'd0;
  localparam size_t SZ_HALF = 2'd1;
  localparam size_t SZ_WORD = 2'd2;
endpackage

// File: rtl/pwb_lane_gen.sv
module pwb_lane_gen
  import pwb_pkg::*;
#(
  parameter int STRB_W = 4,
  localparam int OFF_W = $clog2(STRB_W)
) (
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  size_t             size_i,
  output logic [STRB_W-1:0] strb_o
);
  int unsigned nbytes;
  int unsigned off;
  logic [STRB_W-1:0] ones;

  always_comb begin
    nbytes = 32'd1 << size_i;
    ones   = '0;
    for (int i = 0; i < STRB_W; i++) begin
      if (i < int'(nbytes)) ones[i] = 1'b1;
    end
    off    = 32'(addr_lo_i) & ~(nbytes - 32'd1);
    strb_o = ones << off;
  end
endmodule

// File: rtl/pwb_merge_sel.sv
module pwb_merge_sel #(
  parameter int DEPTH  = 4,
  parameter int WORD_W = 30,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]             count_i,
  input  logic [PTR_W-1:0]             rd_ptr_i,
  input  logic [DEPTH-1:0][WORD_W-1:0] ent_word_i,
  input  logic [DEPTH-1:0]             ent_dev_i,
  input  logic [WORD_W-1:0]            in_word_i,
  output logic                         hit_o,
  output logic [PTR_W-1:0]             idx_o
);
  logic stop;
  int   slot;

  // scan youngest to oldest; a device entry fences off everything older, head excluded
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    stop  = 1'b0;
    slot  = 0;
    for (int k = DEPTH - 1; k >= 1; k--) begin
      slot = (int'(rd_ptr_i) + k) % DEPTH;
      if (k < int'(count_i) && !stop) begin
        if (ent_dev_i[slot]) begin
          stop = 1'b1;
        end else if (ent_word_i[slot] == in_word_i) begin
          stop  = 1'b1;
          hit_o = 1'b1;
          idx_o = PTR_W'(slot);
        end
      end
    end
  end
endmodule

// File: rtl/pwb_store.sv
module pwb_store
  import pwb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int OFF_W  = $clog2(STRB_W),
  localparam int WORD_W = ADDR_W - OFF_W,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         merge_i,
  input  logic [PTR_W-1:0]             merge_idx_i,
  input  logic                         pop_i,
  input  logic [ADDR_W-1:0]            in_addr_i,
  input  logic [DATA_W-1:0]            in_data_i,
  input  size_t                        in_size_i,
  input  logic [STRB_W-1:0]            in_strb_i,
  input  logic                         in_dev_i,
  output logic [CNT_W-1:0]             count_o,
  output logic [PTR_W-1:0]             rd_ptr_o,
  output logic [DEPTH-1:0][WORD_W-1:0] ent_word_o,
  output logic [DEPTH-1:0]             ent_dev_o,
  output logic [ADDR_W-1:0]            head_addr_o,
  output logic [DATA_W-1:0]            head_data_o,
  output size_t                        head_size_o,
  output logic [STRB_W-1:0]            head_strb_o,
  output logic                         head_dev_o
);
  localparam size_t FULL_SZ = size_t'($clog2(STRB_W));

  logic [CNT_W-1:0] count_q;
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;

  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][DATA_W-1:0] ent_data;
  logic [DEPTH-1:0][SIZE_W-1:0] ent_size;
  logic [DEPTH-1:0][STRB_W-1:0] ent_strb;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else begin
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] data_r;
    size_t             size_r;
    logic [STRB_W-1:0] strb_r;
    logic              dev_r;
    logic [STRB_W-1:0] mrg_strb;
    logic [DATA_W-1:0] mrg_data;

    always_comb begin
      mrg_strb = strb_r | in_strb_i;
      for (int b = 0; b < STRB_W; b++) begin
        mrg_data[8*b +: 8] = in_strb_i[b] ? in_data_i[8*b +: 8] : data_r[8*b +: 8];
      end
    end

    always_ff @(posedge clk_i) begin
      if (push_i && wr_ptr_q == PTR_W'(g)) begin
        addr_r <= in_addr_i;
        data_r <= in_data_i;
        size_r <= in_size_i;
        strb_r <= in_strb_i;
        dev_r  <= in_dev_i;
      end else if (merge_i && merge_idx_i == PTR_W'(g)) begin
        data_r <= mrg_data;
        strb_r <= mrg_strb;
        if (mrg_strb != strb_r) begin
          size_r <= FULL_SZ;
          addr_r <= {addr_r[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
      end
    end

    assign ent_addr[g]   = addr_r;
    assign ent_data[g]   = data_r;
    assign ent_size[g]   = size_r;
    assign ent_strb[g]   = strb_r;
    assign ent_dev_o[g]  = dev_r;
    assign ent_word_o[g] = addr_r[ADDR_W-1:OFF_W];
  end

  assign count_o     = count_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign head_addr_o = ent_addr[rd_ptr_q];
  assign head_data_o = ent_data[rd_ptr_q];
  assign head_size_o = ent_size[rd_ptr_q];
  assign head_strb_o = ent_strb[rd_ptr_q];
  assign head_dev_o  = ent_dev_o[rd_ptr_q];

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> int'(count_q) < DEPTH);

  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> count_q != '0);

  // R7
  head_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |-> merge_idx_i != rd_ptr_q);
endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int OFF_W  = $clog2(STRB_W),
  localparam int WORD_W = ADDR_W - OFF_W,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        wr_size_i,
  input  logic              wr_dev_i,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic [1:0]        bus_size_o,
  output logic [STRB_W-1:0] bus_strb_o,
  output logic              bus_dev_o,
  output logic              drained_o
);
  logic [STRB_W-1:0]             in_strb;
  logic [CNT_W-1:0]              count;
  logic [PTR_W-1:0]              rd_ptr;
  logic [DEPTH-1:0][WORD_W-1:0]  ent_word;
  logic [DEPTH-1:0]              ent_dev;
  logic                          sel_hit, hit, full, accept, push, merge, pop;
  logic [PTR_W-1:0]              sel_idx;

  pwb_lane_gen #(.STRB_W(STRB_W)) i_lane (
    .addr_lo_i (wr_addr_i[OFF_W-1:0]),
    .size_i    (wr_size_i),
    .strb_o    (in_strb)
  );

  pwb_merge_sel #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_sel (
    .count_i    (count),
    .rd_ptr_i   (rd_ptr),
    .ent_word_i (ent_word),
    .ent_dev_i  (ent_dev),
    .in_word_i  (wr_addr_i[ADDR_W-1:OFF_W]),
    .hit_o      (sel_hit),
    .idx_o      (sel_idx)
  );

  // device writes never coalesce
  assign hit        = sel_hit && !wr_dev_i;
  assign full       = int'(count) == DEPTH;
  assign wr_ready_o = !full || hit;
  assign accept     = wr_valid_i && wr_ready_o;
  assign push       = accept && !hit;
  assign merge      = accept && hit;
  assign bus_valid_o = count != '0;
  assign pop        = bus_valid_o && bus_ready_i;
  assign drained_o  = count == '0;

  pwb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .merge_i     (merge),
    .merge_idx_i (sel_idx),
    .pop_i       (pop),
    .in_addr_i   (wr_addr_i),
    .in_data_i   (wr_data_i),
    .in_size_i   (wr_size_i),
    .in_strb_i   (in_strb),
    .in_dev_i    (wr_dev_i),
    .count_o     (count),
    .rd_ptr_o    (rd_ptr),
    .ent_word_o  (ent_word),
    .ent_dev_o   (ent_dev),
    .head_addr_o (bus_addr_o),
    .head_data_o (bus_data_o),
    .head_size_o (bus_size_o),
    .head_strb_o (bus_strb_o),
    .head_dev_o  (bus_dev_o)
  );

  // R7
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o) && $stable(bus_data_o)
      && $stable(bus_size_o) && $stable(bus_strb_o) && $stable(bus_dev_o));

  // R5
  dev_append_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_ready_o && wr_dev_i |=> int'(count) == int'($past(count)) + 1 - int'($past(pop)));

  // R3
  merge_no_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge |=> int'(count) == int'($past(count)) - int'($past(pop)));

  // R8
  full_dev_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && wr_ready_o && full |-> !wr_dev_i);

  // R9
  drain_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drained_o) |-> $past(pop));
endmodule

// File: tb/test_posted_wbuf.sv
module test_posted_wbuf;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic        wr_ready_o;
  logic [31:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic        wr_dev_i = 1'b0;
  logic        bus_valid_o;
  logic        bus_ready_i = 1'b0;
  logic [31:0] bus_addr_o;
  logic [31:0] bus_data_o;
  logic [1:0]  bus_size_o;
  logic [3:0]  bus_strb_o;
  logic        bus_dev_o;
  logic        drained_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  posted_wbuf i_posted_wbuf (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wr_size_i(wr_size_i), .wr_dev_i(wr_dev_i),
    .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready_i), .bus_addr_o(bus_addr_o),
    .bus_data_o(bus_data_o), .bus_size_o(bus_size_o), .bus_strb_o(bus_strb_o),
    .bus_dev_o(bus_dev_o), .drained_o(drained_o)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    logic [3:0]  strb;
    logic        dev;
  } item_t;

  item_t exp_q[$];
  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R2";
  bit    done = 1'b0;
  int    seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lane rule of R2
  function automatic logic [3:0] lanes(input logic [31:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001 << a[1:0];
      2'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // expected queue per R3 R4 R5 R6 R7; head (index 0) is never a merge target
  function automatic void model_accept(input logic [31:0] a, input logic [31:0] d,
                                       input logic [1:0] sz, input logic dv);
    item_t it;
    logic [3:0] m;
    logic [3:0] u;
    m = lanes(a, sz);
    if (!dv) begin
      for (int k = exp_q.size() - 1; k >= 1; k--) begin
        if (exp_q[k].dev) break;
        if (exp_q[k].addr[31:2] == a[31:2]) begin
          it = exp_q[k];
          u  = it.strb | m;
          for (int b = 0; b < 4; b++) if (m[b]) it.data[8*b +: 8] = d[8*b +: 8];
          if (u != it.strb) begin
            it.size = 2'd2;
            it.addr = {a[31:2], 2'b00};
          end
          it.strb  = u;
          exp_q[k] = it;
          return;
        end
      end
    end
    it.addr = a; it.data = d; it.size = sz; it.strb = m; it.dev = dv;
    exp_q.push_back(it);
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] d,
                     input logic [1:0] sz, input logic dv);
    @(posedge clk); #1;
    wr_addr_i = a; wr_data_i = d; wr_size_i = sz; wr_dev_i = dv; wr_valid_i = 1'b1;
    while (1) begin
      @(negedge clk);
      if (wr_ready_o) break;
    end
    model_accept(a, d, sz, dv);
    @(posedge clk); #1;
    wr_valid_i = 1'b0;
  endtask

  // R8: offered write must see wr_ready_o low; it is withdrawn unaccepted
  task automatic expect_stall(input logic [31:0] a, input logic [31:0] d,
                              input logic [1:0] sz, input logic dv, input string what);
    @(posedge clk); #1;
    wr_addr_i = a; wr_data_i = d; wr_size_i = sz; wr_dev_i = dv; wr_valid_i = 1'b1;
    @(negedge clk);
    chk(wr_ready_o == 1'b0, "R8", what, wr_ready_o, 0);
    @(posedge clk); #1;
    wr_valid_i = 1'b0;
  endtask

  task automatic drain();
    @(posedge clk); #1;
    bus_ready_i = 1'b1;
    do @(negedge clk); while (!drained_o);
    @(posedge clk); #1;
    bus_ready_i = 1'b0;
    @(negedge clk);
    chk(drained_o == 1'b1 && bus_valid_o == 1'b0, "R9", "drained after drain",
        {drained_o, bus_valid_o}, 2'b10);
    chk(exp_q.size() == 0, cur_req, "missing bus transfers", exp_q.size(), 0);
  endtask

  // monitor: pops scoreboard on each bus handshake
  always @(negedge clk) begin
    item_t e;
    if (rst_n && bus_valid_o && bus_ready_i) begin
      seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected transfer addr", bus_addr_o, 0);
      end else begin
        e = exp_q.pop_front();
        chk(bus_addr_o == e.addr, cur_req, "addr", bus_addr_o, e.addr);
        chk(bus_data_o == e.data, cur_req, "data", bus_data_o, e.data);
        chk({bus_size_o, bus_strb_o, bus_dev_o} == {e.size, e.strb, e.dev}, cur_req,
            "size/strb/dev", {bus_size_o, bus_strb_o, bus_dev_o}, {e.size, e.strb, e.dev});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit stop;
    logic [7:0] lfsr;
    int n_dev;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_valid_o == 1'b0 && wr_ready_o == 1'b1, "R1", "reset valid/ready",
        {bus_valid_o, wr_ready_o}, 2'b01);
    chk(drained_o == 1'b1, "R9", "drained at reset", drained_o, 1);

    // Phase A: fill, stall, merge while full (R3 R4 R8)
    cur_req = "R3 R4";
    put(32'h1000, 32'h1111_1111, 2'd2, 1'b0);
    put(32'h1004, 32'h0000_00AA, 2'd0, 1'b0);
    put(32'h100A, 32'hBBBB_0000, 2'd1, 1'b0);
    put(32'h100C, 32'h3333_3333, 2'd2, 1'b0);
    @(negedge clk);
    chk(drained_o == 1'b0, "R9", "not drained with entries", drained_o, 0);
    expect_stall(32'h2000, 32'h5555_5555, 2'd2, 1'b1, "device write while full");
    expect_stall(32'h3000, 32'h6666_6666, 2'd2, 1'b0, "unmergeable normal while full");
    expect_stall(32'h1008, 32'h7777_7777, 2'd2, 1'b1, "device same-word while full");
    put(32'h1009, 32'h0000_CC00, 2'd0, 1'b0);   // widens entry 2 to word
    put(32'h100C, 32'h4444_4444, 2'd2, 1'b0);   // same lanes: overwrite only
    chk(exp_q.size() == 4, "R8", "merges accepted while full", exp_q.size(), 4);
    drain();

    // Phase B: head excluded from merging (R7)
    cur_req = "R7";
    put(32'h2000, 32'h0A0A_0A0A, 2'd2, 1'b0);
    put(32'h2000, 32'h0000_00B0, 2'd0, 1'b0);
    put(32'h2001, 32'h0000_C100, 2'd0, 1'b0);
    drain();

    // Phase C: repeated device writes to one address (R5)
    cur_req = "R5";
    put(32'h3000, 32'h0000_0001, 2'd2, 1'b1);
    put(32'h3000, 32'h0000_0002, 2'd2, 1'b1);
    put(32'h3000, 32'h0000_0003, 2'd0, 1'b1);
    put(32'h3002, 32'h0004_0000, 2'd1, 1'b1);
    drain();

    // Phase D: device fence blocks older merge target (R6)
    cur_req = "R6";
    put(32'h4000, 32'h0000_0001, 2'd2, 1'b0);
    put(32'h4004, 32'h0000_0002, 2'd2, 1'b0);
    put(32'h5000, 32'h0000_0003, 2'd2, 1'b1);
    put(32'h4004, 32'h0000_00EE, 2'd0, 1'b0);
    put(32'h4004, 32'h0000_FFFF, 2'd1, 1'b0);   // merges into youngest, after the fence
    drain();

    // Phase E: device stream under toggling back-pressure (R2 R5)
    cur_req = "R2";
    stop  = 1'b0;
    lfsr  = 8'hA5;
    seen  = 0;
    n_dev = 40;
    fork
      begin
        for (int i = 0; i < n_dev; i++) begin
          logic [1:0]  sz;
          logic [31:0] a;
          sz = 2'(i % 3);
          a  = 32'h6000 + 32'(4 * (i % 2));
          if (sz == 2'd0) a = a + 32'(i % 4);
          if (sz == 2'd1) a = a + 32'(2 * (i % 2));
          put(a, {4{8'(i)}}, sz, 1'b1);
        end
        stop = 1'b1;
      end
      begin
        while (!stop) begin
          @(posedge clk); #1;
          bus_ready_i = lfsr[0];
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
      end
    join
    drain();
    chk(seen == n_dev, "R5", "one transfer per device write", seen, n_dev);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule